// File: doc/BRIEF.md
# Stochastic Likelihood Product Cell

This block evaluates one grid position of a sensor-fusion posterior using stochastic arithmetic. Three sensors each supply a distance likelihood and a bearing likelihood as serial bitstreams, where the probability of a 1 in a stream stands for the likelihood value. The cell takes one bit from each of the six streams on every valid cycle. It multiplies the six streams by ANDing them together with a tree of two-input gates. No prior term enters the product, because the prior is treated as uniform.

A ones-counter follows the product. It turns the resulting unnormalised posterior stream into a count of ones over a programmable stream length. A start pulse clears the cell and latches the length. After exactly that many accepted bits, the count freezes and a done flag rises. Many copies of the cell run side by side, one per grid position, and they all consume their streams in the same cycles.

Top module: `sc_lik_cell`

## Requirements
- R1: After reset, `count_o` is 0 and `done_o` is 0. Valid bits that arrive before the first `start_i` pulse are not counted.
- R2: Each accepted bit adds one to the count exactly when all six inputs are 1. Any single 0 among the six makes that bit contribute nothing, and no prior term is included.
- R3: `len_sel_i` is sampled in the `start_i` cycle and sets the stream length: 2'b00 gives 64, 2'b01 gives 128, and 2'b10 or 2'b11 gives 256.
- R4: `done_o` rises in the cycle after the clock edge that accepts the last of exactly the programmed number of valid bits. It is 0 while fewer bits have been accepted.
- R5: Once `done_o` is 1, further valid bits change neither `count_o` nor `done_o` until the next `start_i`.
- R6: A cycle with `valid_i` low leaves the count and the accepted-bit total unchanged, whatever `bits_i` carries.
- R7: `start_i` clears the count and `done_o` and restarts the stream, including in the middle of a stream. A valid bit in the same cycle as `start_i` is discarded, and it counts toward neither the ones nor the length.
- R8: The count holds the full 256 when every bit of a 256-bit stream is a product 1.
- R9: Six independent streams with probabilities p0..p5 give a count within a length-dependent tolerance of length × p0·…·p5. Input bit 2k carries the distance stream of sensor k, and bit 2k+1 carries its bearing stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear the cell and latch the stream length |
| len_sel_i | input | 2 | Stream length code (64/128/256) |
| valid_i | input | 1 | Qualifies the six input bits this cycle |
| bits_i | input | 6 | One bit from each likelihood stream |
| count_o | output | 9 | Number of product ones accepted |
| done_o | output | 1 | Programmed length reached; count frozen |

## Verification
Two events can fall in the same cycle: a clear and an incoming valid bit. A second case is the acceptance of the last bit together with the freeze of the count. The bench drives `start_i` and `valid_i` high together with all six bits at 1, then checks that the count reads 0. It then checks that a full programmed length of further bits is still needed before `done_o` rises, which shows the colliding bit was dropped rather than counted. For the freeze case, the bench samples `done_o` one bit before the end, on the end, and after extra valid bits sent past the end.

// File: rtl/sc_cell_pkg.sv
package sc_cell_pkg;

  localparam int LEN_SEL_W = 2;

  // length code k selects base << k, capped at the largest supported length
  function automatic int unsigned decode_len(input logic [LEN_SEL_W-1:0] code,
                                             input int unsigned base_len,
                                             input int unsigned max_len);
    int unsigned l;
    l = base_len << code;
    if (l > max_len) l = max_len;
    return l;
  endfunction

endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sc_and_tree.sv
module sc_and_tree #(
  parameter int N_IN = 6
) (
  input  logic [N_IN-1:0] in_i,
  output logic            prod_o
);
  localparam int N_NODE = 2*N_IN - 1;

  // heap layout: leaves occupy the top N_IN slots, N_IN-1 two-input gates below
  logic [N_NODE-1:0] node;

  always_comb begin
    node = '0;
    for (int i = 0; i < N_IN; i++) node[N_IN-1+i] = in_i[i];
    for (int k = N_IN-2; k >= 0; k--) node[k] = node[2*k+1] & node[2*k+2];
  end

  assign prod_o = node[0];
endmodule

// File: rtl/sc_cell_ctrl.sv
module sc_cell_ctrl
  import sc_cell_pkg::*;
#(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 256,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LEN_SEL_W-1:0] len_sel_i,
  input  logic                 valid_i,
  output logic                 take_o,
  output logic [CNT_W-1:0]     bits_o,
  output logic                 done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             running_q, running_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] bits_q, bits_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             last_bit;

  always_comb begin
    take_o    = running_q & valid_i & ~start_i;
    last_bit  = (bits_q + ONE) == len_q;
    running_d = running_q;
    done_d    = done_q;
    bits_d    = bits_q;
    len_d     = len_q;
    if (start_i) begin
      running_d = 1'b1;
      done_d    = 1'b0;
      bits_d    = '0;
      len_d     = CNT_W'(decode_len(len_sel_i, MIN_LEN, MAX_LEN));
    end else if (take_o) begin
      bits_d = bits_q + ONE;
      if (last_bit) begin
        running_d = 1'b0;
        done_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      bits_q    <= '0;
      len_q     <= CNT_W'(MAX_LEN);
    end else begin
      running_q <= running_d;
      done_q    <= done_d;
      bits_q    <= bits_d;
      len_q     <= len_d;
    end
  end

  assign bits_o = bits_q;
  assign done_o = done_q;

  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= len_q); // R4
  AST_DONE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (bits_q == len_q)); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_q && bits_q == '0)); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> (done_q && $stable(bits_q))); // R5
endmodule

// File: rtl/sc_ones_acc.sv
module sc_ones_acc #(
  parameter int unsigned MAX_LEN = 256,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)               cnt_d = '0;
    else if (take_i && bit_i)  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !clear_i) |=> $stable(cnt_q)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/sc_lik_cell.sv
module sc_lik_cell
  import sc_cell_pkg::*;
#(
  parameter int unsigned NUM_SENSORS = 3,
  parameter int unsigned MIN_LEN     = 64,
  parameter int unsigned MAX_LEN     = 256,
  localparam int N_STREAM = 2 * NUM_SENSORS,
  localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LEN_SEL_W-1:0] len_sel_i,
  input  logic                 valid_i,
  input  logic [N_STREAM-1:0]  bits_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 done_o
);
  logic             rst_n_s;
  logic             prod;
  logic             take;
  logic [CNT_W-1:0] bits_seen;

  sc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  sc_and_tree #(.N_IN(N_STREAM)) u_tree (
    .in_i   (bits_i),
    .prod_o (prod)
  );

  sc_cell_ctrl #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start_i),
    .len_sel_i (len_sel_i),
    .valid_i   (valid_i),
    .take_o    (take),
    .bits_o    (bits_seen),
    .done_o    (done_o)
  );

  sc_ones_acc #(.MAX_LEN(MAX_LEN)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clear_i (start_i),
    .take_i  (take),
    .bit_i   (prod),
    .cnt_o   (count_o)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    count_o <= bits_seen); // R8
  AST_FROZEN_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && !start_i) |=> $stable(count_o)); // R5
endmodule

// File: tb/sc_lik_cell_tb.sv
module sc_lik_cell_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] len_sel_i;
  logic       valid_i;
  logic [5:0] bits_i;
  logic [8:0] count_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_lik_cell dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_sel_i(len_sel_i),
    .valid_i(valid_i), .bits_i(bits_i), .count_o(count_o), .done_o(done_o)
  );

  // {len_sel[22:21], pattern_even[20:15], pattern_odd[14:9], expected[8:0]}
  localparam int NVEC = 7;
  localparam logic [22:0] VEC [NVEC] = '{
    {2'b00, 6'b111111, 6'b111111, 9'd64},   // R2 R3
    {2'b01, 6'b111111, 6'b101111, 9'd64},   // R2 R3
    {2'b10, 6'b111111, 6'b111111, 9'd256},  // R8
    {2'b11, 6'b111111, 6'b111111, 9'd256},  // R3
    {2'b00, 6'b111110, 6'b011111, 9'd0},    // R2
    {2'b01, 6'b000000, 6'b111111, 9'd64},   // R2
    {2'b00, 6'b110111, 6'b111011, 9'd0}     // R2
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive inputs for the next rising edge; outputs read after this call
  // reflect the edge before it
  task automatic cyc(input bit s, input bit v, input logic [5:0] b);
    @(negedge clk);
    start_i = s; valid_i = v; bits_i = b;
  endtask

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'b00) ? 64 : (c == 2'b01) ? 128 : 256;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rng [6];
    int thr [6];
    rst_n = 1'b0; start_i = 1'b0; len_sel_i = 2'b00; valid_i = 1'b0; bits_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, and bits before any start are not counted
    chk(count_o == 0 && done_o == 0, "R1 reset state", count_o, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 6'b111111);
    cyc(0, 0, 0);
    chk(count_o == 0 && done_o == 0, "R1 no count before start", count_o, 0);

    // table walk
    for (int e = 0; e < NVEC; e++) begin
      int n;
      len_sel_i = VEC[e][22:21];
      cyc(1, 0, 0);
      n = len_of(VEC[e][22:21]);
      for (int i = 0; i < n; i++) begin
        cyc(0, 1, (i % 2 == 0) ? VEC[e][20:15] : VEC[e][14:9]);
        if (i == n - 1) chk(done_o == 0, "R4 done low before last bit", done_o, 0);
      end
      cyc(0, 0, 0);
      chk(count_o == VEC[e][8:0], "R2 table count", count_o, VEC[e][8:0]);
      chk(done_o == 1, "R4 done after length", done_o, 1);
    end

    // R5: valid bits after done are ignored
    cyc(0, 1, 6'b111111);
    cyc(0, 1, 6'b111111);
    cyc(0, 0, 0);
    chk(count_o == 0 && done_o == 1, "R5 frozen after done", count_o, 0);

    // R6: invalid cycles carrying ones are ignored
    len_sel_i = 2'b00;
    cyc(1, 0, 0);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 1, 6'b111111);
      cyc(0, 0, 6'b111111);
    end
    cyc(0, 0, 0);
    chk(count_o == 10 && done_o == 0, "R6 invalid ignored", count_o, 10);
    for (int i = 0; i < 54; i++) begin
      cyc(0, 0, 6'b111111);
      cyc(0, 1, 6'b111111);
    end
    cyc(0, 0, 0);
    chk(count_o == 64 && done_o == 1, "R6 length counts valid only", count_o, 64);

    // R7: start and valid in the same cycle, bit discarded
    cyc(1, 1, 6'b111111);
    cyc(0, 0, 0);
    chk(count_o == 0 && done_o == 0, "R7 start wins over valid", count_o, 0);
    for (int i = 0; i < 63; i++) cyc(0, 1, 6'b111111);
    cyc(0, 0, 0);
    chk(done_o == 0, "R7 colliding bit not in length", done_o, 0);
    cyc(0, 1, 6'b111111);
    cyc(0, 0, 0);
    chk(count_o == 64 && done_o == 1, "R7 full length after collision", count_o, 64);

    // R7: clear mid-stream
    len_sel_i = 2'b01;
    cyc(1, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 6'b111111);
    len_sel_i = 2'b00;
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    chk(count_o == 0 && done_o == 0, "R7 mid-stream clear", count_o, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 6'b111111);
    cyc(0, 0, 0);
    chk(count_o == 64 && done_o == 1, "R3 relatched length", count_o, 64);

    // R9: independent stochastic sources, one comparator per stream
    thr = '{240, 232, 224, 248, 216, 236};
    rng = '{32'h1234_5679, 32'h9E37_79B9, 32'hDEAD_BEEF, 32'h0BAD_F00D,
            32'h7F4A_7C15, 32'hC0FF_EE01};
    for (int w = 0; w < 40; w++)
      for (int k = 0; k < 6; k++) rng[k] = xs(rng[k]);
    for (int c = 0; c < 3; c++) begin
      int n; int exact; real p; int tol; int dev;
      n = len_of(2'(c));
      p = 1.0;
      for (int k = 0; k < 6; k++) p = p * (real'(thr[k]) / 256.0);
      tol = n / 8 + 8;
      exact = 0;
      len_sel_i = 2'(c);
      cyc(1, 0, 0);
      for (int i = 0; i < n; i++) begin
        logic [5:0] b;
        for (int k = 0; k < 6; k++) begin
          rng[k] = xs(rng[k]);
          b[k] = (int'(rng[k][31:24]) < thr[k]);
        end
        if (&b) exact++;
        cyc(0, 1, b);
      end
      cyc(0, 0, 0);
      chk(count_o == exact, "R2 stochastic exact", count_o, exact);
      dev = int'(count_o) - int'(p * real'(n));
      if (dev < 0) dev = -dev;
      chk(dev <= tol, "R9 product tolerance", count_o, int'(p * real'(n)));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule